// File: doc/BRIEF.md
# Multiplexed Host Port Slave

This block lets an external microcontroller reach a local memory through a narrow set of pins. Addresses and data share one bidirectional 16-bit bus. A two-bit select chooses what the host is talking to: a control word, an address pointer, or the memory word at that pointer. One of the memory selections advances the pointer after every access, so the host can stream through a buffer without reloading the address. Each memory access pulls the ready line low for two clocks while the memory port completes its single-cycle read or write.

The control word carries two interrupt flags. The host sets the first flag to interrupt the local processor, and the local side acknowledges it. The local side sets the second flag to interrupt the host, which shows on an active-low interrupt pin; the host clears it by writing a one. All host pins are sampled on the block's clock, and an access starts when chip select and the data strobe are both low.

The controller is a four-state machine. ST_IDLE waits for a strobe. A strobe on a memory selection takes the IDLE-to-MEM transition, and a strobe on a register selection takes the IDLE-to-HOLD transition. ST_MEM issues the memory request and always moves to ST_WAIT. ST_WAIT captures read data, advances the pointer when asked to, and always moves to ST_HOLD. ST_HOLD waits for the strobe to be released and then returns to ST_IDLE.

Top module: `hpi_slave`

## Requirements
- R1: After reset, hrdy is 1, hint_n is 1, lcl_irq is 0, the address pointer reads 0, the control word reads 0, and hd is not driven.
- R2: The select encoding on hcntl is 00 for the control word, 01 for memory with post-increment, 10 for the address pointer, and 11 for memory without increment.
- R3: A host write with hcntl=10 loads the low AW bits of hd into the address pointer. A read with hcntl=10 returns the pointer zero-extended to 16 bits.
- R4: A host write with hcntl=11 stores hd into memory at the pointer and leaves the pointer unchanged.
- R5: A host read with hcntl=01 or hcntl=11 returns the memory word at the pointer on hd once hrdy is high again.
- R6: Each access with hcntl=01 adds one to the pointer after the memory operation, wrapping from 2^AW-1 to 0.
- R7: On a memory access, hrdy goes low in the clock after the strobe is first sampled and stays low for exactly two clocks. Register accesses never drop hrdy.
- R8: The block drives hd only while hcs_n and hds_n are both low and hrw is 1 (read). At all other times a value the host drives is seen on hd unchanged.
- R9: Writing a 1 to bit 0 of the control word sets lcl_irq, and writing a 0 there has no effect. A pulse on lcl_ack clears lcl_irq. Bit 0 reads back the flag.
- R10: A pulse on hirq_set sets bit 1 of the control word and drives hint_n low. A host write with bit 1 set clears the flag, and a write with bit 1 clear leaves it as it is.
- R11: A strobe while hcs_n is high is ignored.
- R12: A data strobe held low for many clocks performs exactly one memory access and at most one increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all host pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| hcs_n | input | 1 | Host chip select, active low |
| hds_n | input | 1 | Host data strobe, active low |
| hrw | input | 1 | 1 = host reads, 0 = host writes |
| hcntl | input | 2 | Target select (see R2) |
| hd | inout | DW | Shared address/data bus |
| hrdy | output | 1 | 1 = access may complete, 0 = busy |
| hint_n | output | 1 | Host interrupt, active low |
| lcl_irq | output | 1 | Interrupt request toward the local processor |
| lcl_ack | input | 1 | Local side clears lcl_irq |
| hirq_set | input | 1 | Local side raises the host interrupt |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Write enable qualifying mem_req |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one clock after mem_req |

## Verification
The bench builds the block with AW=6, so the memory has only 64 words. A full burst with post-increment therefore runs through every location and wraps the pointer back to zero within a short run. With DW kept at 16, the zero-extension path for the pointer readback is exercised, and the unused upper bits of an address write can be checked to be dropped. Random mixes of pointer loads and both memory selections are checked against a reference memory and a reference pointer. Directed cases cover the interrupt flags, an ignored strobe, and a long strobe.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL     = 2'b00,
        SEL_DATA_INC = 2'b01,
        SEL_ADDR     = 2'b10,
        SEL_DATA     = 2'b11
    } hpi_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEM,
        ST_WAIT,
        ST_HOLD
    } hpi_state_e;

    localparam int CTL_LIRQ_BIT = 0;
    localparam int CTL_HIRQ_BIT = 1;

endpackage

// File: rtl/hpi_strobe.sv
module hpi_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic hcs_n,
    input  logic hds_n,
    output logic strb_act,
    output logic strb_start
);
    logic strb_q;

    assign strb_act   = ~hcs_n & ~hds_n;
    assign strb_start = strb_act & ~strb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strb_q <= 1'b0;
        else        strb_q <= strb_act;
    end
endmodule

// File: rtl/hpi_fsm.sv
module hpi_fsm
    import hpi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strb_act,
    input  logic       strb_start,
    input  logic [1:0] sel,
    input  logic       hrw,
    output logic       hrdy,
    output logic       mem_req,
    output logic       mem_we,
    output logic       ctl_wr,
    output logic       adr_wr,
    output logic       wd_cap,
    output logic       rd_cap,
    output logic       inc_pulse
);
    hpi_state_e state, nxt;
    logic       cmd_rd_q;
    logic       cmd_inc_q;
    logic       is_data;

    assign is_data = sel[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_rd_q  <= 1'b0;
            cmd_inc_q <= 1'b0;
        end else if (state == ST_IDLE && strb_start) begin
            cmd_rd_q  <= hrw;
            cmd_inc_q <= (sel == SEL_DATA_INC);
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (strb_start) nxt = is_data ? ST_MEM : ST_HOLD;
            ST_MEM:  nxt = ST_WAIT;
            ST_WAIT: nxt = ST_HOLD;
            ST_HOLD: if (!strb_act) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        hrdy      = 1'b1;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        ctl_wr    = 1'b0;
        adr_wr    = 1'b0;
        wd_cap    = 1'b0;
        rd_cap    = 1'b0;
        inc_pulse = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (strb_start) begin
                    ctl_wr = (sel == SEL_CTRL) & ~hrw;
                    adr_wr = (sel == SEL_ADDR) & ~hrw;
                    wd_cap = is_data;
                end
            end
            ST_MEM: begin
                hrdy    = 1'b0;
                mem_req = 1'b1;
                mem_we  = ~cmd_rd_q;
            end
            ST_WAIT: begin
                hrdy      = 1'b0;
                rd_cap    = cmd_rd_q;
                inc_pulse = cmd_inc_q;
            end
            ST_HOLD: ;
            default: ;
        endcase
    end

    AST_WAIT_FOLLOWS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (!hrdy && !mem_req)); // R7
    AST_HOLD_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!hrdy && !mem_req) |=> hrdy); // R7
endmodule

// File: rtl/hpi_regs.sv
module hpi_regs
    import hpi_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] hd_in,
    input  logic          ctl_wr,
    input  logic          adr_wr,
    input  logic          wd_cap,
    input  logic          rd_cap,
    input  logic          inc_pulse,
    input  logic [DW-1:0] mem_rdata,
    input  logic          lcl_ack,
    input  logic          hirq_set,
    output logic [AW-1:0] hpia,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_latch,
    output logic [DW-1:0] ctl_word,
    output logic          lcl_irq,
    output logic          hirq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hpia <= '0;
        else if (adr_wr)    hpia <= hd_in[AW-1:0];
        else if (inc_pulse) hpia <= hpia + AW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata    <= '0;
            rd_latch <= '0;
        end else begin
            if (wd_cap) wdata    <= hd_in;
            if (rd_cap) rd_latch <= mem_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcl_irq <= 1'b0;
            hirq    <= 1'b0;
        end else begin
            if (ctl_wr && hd_in[CTL_LIRQ_BIT]) lcl_irq <= 1'b1;
            else if (lcl_ack)                  lcl_irq <= 1'b0;
            if (hirq_set)                          hirq <= 1'b1;
            else if (ctl_wr && hd_in[CTL_HIRQ_BIT]) hirq <= 1'b0;
        end
    end

    always_comb begin
        ctl_word               = '0;
        ctl_word[CTL_LIRQ_BIT] = lcl_irq;
        ctl_word[CTL_HIRQ_BIT] = hirq;
    end

    AST_LIRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && hd_in[CTL_LIRQ_BIT]) |=> lcl_irq); // R9
    AST_HIRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hirq_set |=> hirq); // R10
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adr_wr && !inc_pulse) |=> $stable(hpia)); // R3
endmodule

// File: rtl/hpi_slave.sv
module hpi_slave
    import hpi_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hcs_n,
    input  logic          hds_n,
    input  logic          hrw,
    input  logic [1:0]    hcntl,
    inout  wire  [DW-1:0] hd,
    output logic          hrdy,
    output logic          hint_n,
    output logic          lcl_irq,
    input  logic          lcl_ack,
    input  logic          hirq_set,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    logic          strb_act, strb_start;
    logic          ctl_wr, adr_wr, wd_cap, rd_cap, inc_pulse;
    logic [AW-1:0] hpia;
    logic [DW-1:0] rd_latch, ctl_word, addr_word, out_data;
    logic          hirq;
    logic          hd_oe;

    hpi_strobe u_strobe (
        .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .hds_n(hds_n),
        .strb_act(strb_act), .strb_start(strb_start)
    );

    hpi_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .strb_act(strb_act), .strb_start(strb_start),
        .sel(hcntl), .hrw(hrw), .hrdy(hrdy), .mem_req(mem_req), .mem_we(mem_we),
        .ctl_wr(ctl_wr), .adr_wr(adr_wr), .wd_cap(wd_cap), .rd_cap(rd_cap),
        .inc_pulse(inc_pulse)
    );

    hpi_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .hd_in(hd), .ctl_wr(ctl_wr), .adr_wr(adr_wr),
        .wd_cap(wd_cap), .rd_cap(rd_cap), .inc_pulse(inc_pulse),
        .mem_rdata(mem_rdata), .lcl_ack(lcl_ack), .hirq_set(hirq_set),
        .hpia(hpia), .wdata(mem_wdata), .rd_latch(rd_latch), .ctl_word(ctl_word),
        .lcl_irq(lcl_irq), .hirq(hirq)
    );

    generate
        if (AW < DW) begin : g_addr_pad
            assign addr_word = {{(DW-AW){1'b0}}, hpia};
        end else begin : g_addr_full
            assign addr_word = hpia[DW-1:0];
        end
    endgenerate

    always_comb begin
        unique case (hcntl)
            SEL_CTRL: out_data = ctl_word;
            SEL_ADDR: out_data = addr_word;
            default:  out_data = rd_latch;
        endcase
    end

    assign hd_oe    = strb_act & hrw;
    assign hd       = hd_oe ? out_data : 'z;
    assign mem_addr = hpia;
    assign hint_n   = ~hirq;

    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !hrdy); // R7
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R12
    AST_NO_CS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (hcs_n && hrdy) |=> !mem_req); // R11
endmodule

// File: tb/hpi_slave_tb_top.sv
`timescale 1ns/1ps
module hpi_slave_tb_top;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hcs_n = 1'b0, hds_n = 1'b1, hrw = 1'b1;
    logic [1:0]    hcntl = 2'b00;
    logic          lcl_ack = 1'b0, hirq_set = 1'b0;
    logic          drv_en = 1'b0;
    logic [DW-1:0] drv_val = '0;
    wire  [DW-1:0] hd;
    logic          hrdy, hint_n, lcl_irq, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    logic [DW-1:0] ram [DEPTH];
    logic [DW-1:0] ref_mem [DEPTH];
    logic [AW-1:0] ref_ptr;
    int            n_chk = 0, n_fail = 0, cyc = 0;

    assign hd = drv_en ? drv_val : 'z;

    always #2 clk = ~clk;

    hpi_slave #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .hds_n(hds_n), .hrw(hrw),
        .hcntl(hcntl), .hd(hd), .hrdy(hrdy), .hint_n(hint_n), .lcl_irq(lcl_irq),
        .lcl_ack(lcl_ack), .hirq_set(hirq_set), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            mem_rdata <= ram[mem_addr];
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] fill_val(input int i);
        return 16'(i * 16'h0101) ^ 16'h3C00;
    endfunction

    task automatic hop(input logic [1:0] c, input logic rw, input logic [DW-1:0] wv,
                       input logic csn, input int hold,
                       output logic [DW-1:0] rv, output int busy);
        @(negedge clk);
        hcntl = c; hrw = rw; hcs_n = csn; drv_en = !rw; drv_val = wv;
        @(negedge clk);
        hds_n = 1'b0;
        busy = 0;
        @(negedge clk);
        while (!hrdy && busy < 20) begin
            busy++;
            @(negedge clk);
        end
        repeat (hold) @(negedge clk);
        rv = hd;
        hds_n = 1'b1; drv_en = 1'b0; hcs_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        logic [DW-1:0] rv;
        int busy;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 hrdy", {15'd0, hrdy}, 16'd1);
        chk("R1 hint_n", {15'd0, hint_n}, 16'd1);
        chk("R1 lcl_irq", {15'd0, lcl_irq}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        hop(2'b10, 1'b1, '0, 1'b0, 0, rv, busy);
        chk("R1 pointer reset", rv, 16'd0);
        hop(2'b00, 1'b1, '0, 1'b0, 0, rv, busy);
        chk("R1 control reset", rv, 16'd0);
        chk("R7 register access keeps hrdy", 16'(busy), 16'd0);

        // R3: upper bits dropped, readback zero-extended
        hop(2'b10, 1'b0, 16'hFFC0, 1'b0, 0, rv, busy);
        hop(2'b10, 1'b1, '0, 1'b0, 0, rv, busy);
        chk("R3 pointer zero-extend", rv, 16'd0);

        // R6 fill with post-increment, full wrap
        for (int i = 0; i < DEPTH; i++) begin
            hop(2'b01, 1'b0, fill_val(i), 1'b0, 0, rv, busy);
            ref_mem[i] = fill_val(i);
            if (i == 0) begin
                chk("R7 write busy two clocks", 16'(busy), 16'd2);
                chk("R8 host value seen during write strobe", rv, fill_val(0));
            end
        end
        hop(2'b10, 1'b1, '0, 1'b0, 0, rv, busy);
        chk("R6 pointer wrapped", rv, 16'd0);
        for (int i = 0; i < DEPTH; i++) begin
            hop(2'b01, 1'b1, '0, 1'b0, 0, rv, busy);
            chk("R5 burst read", rv, ref_mem[i]);
            if (i == 0) chk("R7 read busy two clocks", 16'(busy), 16'd2);
        end

        // R4 no-increment write/read
        hop(2'b10, 1'b0, 16'd5, 1'b0, 0, rv, busy);
        hop(2'b11, 1'b0, 16'hBEEF, 1'b0, 0, rv, busy);
        ref_mem[5] = 16'hBEEF;
        hop(2'b10, 1'b1, '0, 1'b0, 0, rv, busy);
        chk("R4 pointer unchanged after write", rv, 16'd5);
        hop(2'b11, 1'b1, '0, 1'b0, 0, rv, busy);
        chk("R5 read without increment", rv, 16'hBEEF);
        hop(2'b10, 1'b1, '0, 1'b0, 0, rv, busy);
        chk("R4 pointer unchanged after read", rv, 16'd5);

        // R9 local interrupt
        hop(2'b00, 1'b0, 16'd0, 1'b0, 0, rv, busy);
        chk("R9 write 0 no effect", {15'd0, lcl_irq}, 16'd0);
        hop(2'b00, 1'b0, 16'd1, 1'b0, 0, rv, busy);
        chk("R9 lcl_irq set", {15'd0, lcl_irq}, 16'd1);
        hop(2'b00, 1'b1, '0, 1'b0, 0, rv, busy);
        chk("R9 control bit0 readback", rv, 16'd1);
        @(negedge clk); lcl_ack = 1'b1; @(negedge clk); lcl_ack = 1'b0;
        chk("R9 lcl_irq cleared by ack", {15'd0, lcl_irq}, 16'd0);

        // R10 host interrupt
        @(negedge clk); hirq_set = 1'b1; @(negedge clk); hirq_set = 1'b0;
        chk("R10 hint_n low", {15'd0, hint_n}, 16'd0);
        hop(2'b00, 1'b1, '0, 1'b0, 0, rv, busy);
        chk("R10 control bit1 readback", rv, 16'd2);
        hop(2'b00, 1'b0, 16'd0, 1'b0, 0, rv, busy);
        chk("R10 write 0 keeps flag", {15'd0, hint_n}, 16'd0);
        hop(2'b00, 1'b0, 16'd2, 1'b0, 0, rv, busy);
        chk("R10 write 1 clears flag", {15'd0, hint_n}, 16'd1);

        // R11 ignored strobe
        hop(2'b10, 1'b0, 16'd33, 1'b1, 0, rv, busy);
        hop(2'b11, 1'b0, 16'h1111, 1'b1, 0, rv, busy);
        hop(2'b10, 1'b1, '0, 1'b0, 0, rv, busy);
        chk("R11 pointer unchanged", rv, 16'd5);
        hop(2'b11, 1'b1, '0, 1'b0, 0, rv, busy);
        chk("R11 memory unchanged", rv, 16'hBEEF);

        // R12 long strobe
        hop(2'b10, 1'b0, 16'd10, 1'b0, 0, rv, busy);
        hop(2'b01, 1'b0, 16'hCAFE, 1'b0, 8, rv, busy);
        ref_mem[10] = 16'hCAFE;
        hop(2'b10, 1'b1, '0, 1'b0, 0, rv, busy);
        chk("R12 single increment", rv, 16'd11);
        hop(2'b11, 1'b1, '0, 1'b0, 0, rv, busy);
        chk("R12 next word untouched", rv, ref_mem[11]);

        // R8 idle bus carries host value
        @(negedge clk); hrw = 1'b1; drv_en = 1'b1; drv_val = 16'hA5A5;
        @(negedge clk);
        chk("R8 idle bus not driven", hd, 16'hA5A5);
        drv_en = 1'b0;

        // R2 random mix against reference
        ref_ptr = 6'd11;
        for (int n = 0; n < 400; n++) begin
            logic [1:0] c;
            logic rw;
            logic [DW-1:0] v;
            c = 2'($urandom_range(1, 3));
            rw = 1'($urandom);
            v = 16'($urandom);
            hop(c, rw, v, 1'b0, 0, rv, busy);
            if (c == 2'b10) begin
                if (rw) chk("R2 R3 random pointer read", rv, {10'd0, ref_ptr});
                else ref_ptr = v[AW-1:0];
            end else begin
                if (rw) chk("R2 R5 random memory read", rv, ref_mem[ref_ptr]);
                else ref_mem[ref_ptr] = v;
                chk("R7 random busy", 16'(busy), 16'd2);
                if (c == 2'b01) ref_ptr = ref_ptr + 6'd1;
            end
        end
        hop(2'b10, 1'b1, '0, 1'b0, 0, rv, busy);
        chk("R6 final pointer", rv, {10'd0, ref_ptr});
        finish_run();
    end
endmodule